// File: doc/BRIEF.md
# Per-Object Moment Splitter

This block sits behind a column-parallel moment array. For each image column it receives two sums: the pixel count of that column (its zeroth moment) and the sum of row indices of the set pixels (its first row moment). The targets in the image have already been chosen so that no two of them share a column, so every column holds pixels of at most one object. The block cuts the column stream into objects wherever a column is empty. It accumulates the full-image moments of each object, including the terms weighted by column position. It then hands out one record per object.

Columns arrive one per cycle while `col_vld` is high. The column index is implied by arrival order: it starts at 0 after reset and wraps after the last column of a frame. A fixed pool of accumulator units (four by default) collects objects concurrently. An object that finds every unit occupied is discarded and flagged. Finished records leave through a valid/ready handshake, in the order in which their objects began. The second-order terms can be removed with a parameter.

Top module: `msp_object_splitter`

## Requirements
- R1: After reset, `rec_valid` and `obj_drop` are both low until columns are supplied.
- R2: An object is a maximal run of adjacent columns, within one frame, whose pixel count is nonzero. A column with zero pixel count ends the run, and the row sum of such a column has no effect on any record.
- R3: A record's `rec_m00` equals the sum of the pixel counts of its columns, and `rec_m01` equals the sum of their row sums.
- R4: With x the column index (0 to NCOL-1), `rec_m10` = Σ x·count, `rec_m20` = Σ x²·count and `rec_m11` = Σ x·rowsum over the object's columns.
- R5: Records are emitted in the order of their starting column, and across frames in arrival order.
- R6: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and every record field stays unchanged.
- R7: An object whose first column arrives while all NUNIT units hold unreleased objects yields no record and raises `obj_drop` for exactly one cycle, the cycle after that column.
- R8: A unit becomes free in the cycle after its record is accepted and can then take a new object.
- R9: Column NCOL-1 always closes an open object, and column 0 of the next frame always starts a new one, even when both columns are occupied.
- R10: Cycles with `col_vld` low change no record and do not advance the column index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_vld | input | 1 | A column's sums are present this cycle |
| col_m00 | input | C0W | Set-pixel count of the column |
| col_m01 | input | C1W | Sum of row indices of the column's set pixels |
| rec_valid | output | 1 | An object record is offered |
| rec_ready | input | 1 | Downstream accepts the offered record |
| rec_m00 | output | A00W | Object area |
| rec_m10 | output | A10W | Column-weighted sum |
| rec_m20 | output | A20W | Squared-column-weighted sum (zero when second order is off) |
| rec_m01 | output | A01W | Row-weighted sum |
| rec_m11 | output | A11W | Row-by-column product sum (zero when second order is off) |
| obj_drop | output | 1 | One-cycle pulse: an object was discarded for lack of a unit |

## Verification
Exhausting the unit pool cannot happen while the consumer is always ready. A record leaves in the cycle after its object closes, and the mandatory empty column between objects means that at most two units are ever taken at once. To reach the overflow and hold cases, the stimulus holds `rec_ready` low for a whole frame of densely packed, alternating occupied and empty columns. It then releases it and checks that exactly the first four objects come out and that one drop pulse is seen for each of the others. Long free-running sweeps of derived column masks, with idle beats inserted, cover run splitting and frame wrap.

// File: rtl/msp_pkg.sv
package msp_pkg;
  // Classification of one incoming column beat
  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,  // no beat this cycle
    CK_GAP   = 2'd1,  // empty column
    CK_START = 2'd2,  // first column of a new object
    CK_CONT  = 2'd3   // further column of the current object
  } col_kind_e;
endpackage

// File: rtl/msp_col_tracker.sv
module msp_col_tracker #(
  parameter int NCOL = 16,
  parameter int C0W  = 5,
  parameter int XW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                col_vld,
  input  logic [C0W-1:0]      col_m00,
  output logic [XW-1:0]       col_x,
  output logic                col_last,
  output msp_pkg::col_kind_e  col_kind
);
  import msp_pkg::*;

  logic [XW-1:0] x_q, x_d;
  logic          pz_q, pz_d;   // previous column was empty
  logic          nz;

  always_comb begin
    nz       = (col_m00 != '0);
    col_last = (x_q == XW'(NCOL - 1));
    if (!col_vld)                       col_kind = CK_IDLE;
    else if (!nz)                       col_kind = CK_GAP;
    else if ((x_q == '0) || pz_q)       col_kind = CK_START;
    else                                col_kind = CK_CONT;
    x_d  = col_last ? '0 : x_q + XW'(1);
    pz_d = ~nz;
  end

  assign col_x = x_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      pz_q <= 1'b1;
    end else if (col_vld) begin
      x_q  <= x_d;
      pz_q <= pz_d;
    end
  end
endmodule

// File: rtl/msp_acc_unit.sv
module msp_acc_unit #(
  parameter int XW   = 4,
  parameter int C0W  = 5,
  parameter int C1W  = 7,
  parameter int A00W = 9,
  parameter int A10W = 13,
  parameter int A20W = 17,
  parameter int A01W = 11,
  parameter int A11W = 15,
  parameter int SECOND_ORDER = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            add,
  input  logic [XW-1:0]   x,
  input  logic [C0W-1:0]  c0,
  input  logic [C1W-1:0]  c1,
  output logic [A00W-1:0] m00,
  output logic [A10W-1:0] m10,
  output logic [A20W-1:0] m20,
  output logic [A01W-1:0] m01,
  output logic [A11W-1:0] m11
);
  logic            en;
  logic [A00W-1:0] m00_q, m00_d;
  logic [A10W-1:0] m10_q, m10_d, t10;
  logic [A01W-1:0] m01_q, m01_d;

  always_comb begin
    en    = load | add;
    t10   = A10W'(x) * A10W'(c0);
    m00_d = (add ? m00_q : '0) + A00W'(c0);
    m10_d = (add ? m10_q : '0) + t10;
    m01_d = (add ? m01_q : '0) + A01W'(c1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m00_q <= '0;
      m10_q <= '0;
      m01_q <= '0;
    end else if (en) begin
      m00_q <= m00_d;
      m10_q <= m10_d;
      m01_q <= m01_d;
    end
  end

  assign m00 = m00_q;
  assign m10 = m10_q;
  assign m01 = m01_q;

  generate
    if (SECOND_ORDER != 0) begin : g_second
      logic [A20W-1:0] m20_q, m20_d, t20;
      logic [A11W-1:0] m11_q, m11_d, t11;
      always_comb begin
        t20   = A20W'(x) * A20W'(x) * A20W'(c0);
        t11   = A11W'(x) * A11W'(c1);
        m20_d = (add ? m20_q : '0) + t20;
        m11_d = (add ? m11_q : '0) + t11;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          m20_q <= '0;
          m11_q <= '0;
        end else if (en) begin
          m20_q <= m20_d;
          m11_q <= m11_d;
        end
      end
      assign m20 = m20_q;
      assign m11 = m11_q;
    end else begin : g_first
      assign m20 = '0;
      assign m11 = '0;
    end
  endgenerate
endmodule

// File: rtl/msp_order_fifo.sv
module msp_order_fifo #(
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] head,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    rp_d  = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    cnt_d = cnt_q + CW'(push) - CW'(pop);
    empty = (cnt_q == '0);
    head  = mem_q[rp_q];
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= push_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push)        wp_q  <= wp_d;
      if (pop)         rp_q  <= rp_d;
      if (push || pop) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/msp_object_splitter.sv
module msp_object_splitter #(
  parameter int NCOL         = 16,
  parameter int NROW         = 16,
  parameter int NUNIT        = 4,
  parameter int SECOND_ORDER = 1,
  localparam int XW   = $clog2(NCOL),
  localparam int C0W  = $clog2(NROW + 1),
  localparam int C1W  = $clog2(NROW * (NROW - 1) / 2 + 1),
  localparam int A00W = C0W + XW,
  localparam int A10W = A00W + XW,
  localparam int A20W = A10W + XW,
  localparam int A01W = C1W + XW,
  localparam int A11W = A01W + XW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            col_vld,
  input  logic [C0W-1:0]  col_m00,
  input  logic [C1W-1:0]  col_m01,
  output logic            rec_valid,
  input  logic            rec_ready,
  output logic [A00W-1:0] rec_m00,
  output logic [A10W-1:0] rec_m10,
  output logic [A20W-1:0] rec_m20,
  output logic [A01W-1:0] rec_m01,
  output logic [A11W-1:0] rec_m11,
  output logic            obj_drop
);
  import msp_pkg::*;

  localparam int IW = $clog2(NUNIT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  // column classification
  logic [XW-1:0] cx;
  logic          clast;
  col_kind_e     ckind;

  msp_col_tracker #(.NCOL(NCOL), .C0W(C0W), .XW(XW)) u_trk (
    .clk(clk), .rst_n(rst_sn), .col_vld(col_vld), .col_m00(col_m00),
    .col_x(cx), .col_last(clast), .col_kind(ckind)
  );

  // unit pool state
  logic [NUNIT-1:0] unit_busy, busy_d, done_q, done_d;
  logic [NUNIT-1:0] u_load, u_add;
  logic             open_q, open_d;
  logic [IW-1:0]    cur_q, cur_d;
  logic             drop_q;
  logic             any_free, start_ok, ovf_now, close_cur, close_new, fire;
  logic [IW-1:0]    alloc_idx, head;
  logic             q_empty;

  always_comb begin
    any_free  = 1'b0;
    alloc_idx = '0;
    for (int i = NUNIT - 1; i >= 0; i--) begin
      if (!unit_busy[i]) begin
        any_free  = 1'b1;
        alloc_idx = IW'(i);
      end
    end
    start_ok  = (ckind == CK_START) && any_free;
    ovf_now   = (ckind == CK_START) && !any_free;
    close_cur = open_q && ((ckind == CK_GAP) || ((ckind == CK_CONT) && clast));
    close_new = start_ok && clast;
    rec_valid = !q_empty && done_q[head];
    fire      = rec_valid && rec_ready;

    for (int i = 0; i < NUNIT; i++) begin
      u_load[i] = start_ok && (alloc_idx == IW'(i));
      u_add[i]  = (ckind == CK_CONT) && open_q && (cur_q == IW'(i));
      busy_d[i] = (unit_busy[i] | u_load[i]) & ~(fire && (head == IW'(i)));
      done_d[i] = (done_q[i] | (close_cur && (cur_q == IW'(i))) | (close_new && u_load[i]))
                  & ~(fire && (head == IW'(i)));
    end

    open_d = open_q;
    cur_d  = cur_q;
    if (start_ok && !clast) begin
      open_d = 1'b1;
      cur_d  = alloc_idx;
    end else if (close_cur) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      unit_busy <= '0;
      done_q    <= '0;
      open_q    <= 1'b0;
      cur_q     <= '0;
      drop_q    <= 1'b0;
    end else begin
      unit_busy <= busy_d;
      done_q    <= done_d;
      drop_q    <= ovf_now;
      if (col_vld) begin
        open_q <= open_d;
        cur_q  <= cur_d;
      end
    end
  end

  assign obj_drop = drop_q;

  msp_order_fifo #(.DEPTH(NUNIT), .IW(IW)) u_ord (
    .clk(clk), .rst_n(rst_sn), .push(start_ok), .push_idx(alloc_idx),
    .pop(fire), .head(head), .empty(q_empty)
  );

  // accumulator units
  logic [A00W-1:0] u_m00 [NUNIT];
  logic [A10W-1:0] u_m10 [NUNIT];
  logic [A20W-1:0] u_m20 [NUNIT];
  logic [A01W-1:0] u_m01 [NUNIT];
  logic [A11W-1:0] u_m11 [NUNIT];

  generate
    for (genvar g = 0; g < NUNIT; g++) begin : g_unit
      msp_acc_unit #(
        .XW(XW), .C0W(C0W), .C1W(C1W), .A00W(A00W), .A10W(A10W),
        .A20W(A20W), .A01W(A01W), .A11W(A11W), .SECOND_ORDER(SECOND_ORDER)
      ) u_acc (
        .clk(clk), .rst_n(rst_sn), .load(u_load[g]), .add(u_add[g]),
        .x(cx), .c0(col_m00), .c1(col_m01),
        .m00(u_m00[g]), .m10(u_m10[g]), .m20(u_m20[g]),
        .m01(u_m01[g]), .m11(u_m11[g])
      );
    end
  endgenerate

  assign rec_m00 = u_m00[head];
  assign rec_m10 = u_m10[head];
  assign rec_m20 = u_m20[head];
  assign rec_m01 = u_m01[head];
  assign rec_m11 = u_m11[head];
endmodule

// File: rtl/msp_splitter_checker.sv
module msp_splitter_checker #(
  parameter int NCOL  = 16,
  parameter int NUNIT = 4,
  parameter int A00W  = 9,
  parameter int A10W  = 13,
  parameter int A01W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             col_vld,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [A00W-1:0]  rec_m00,
  input logic [A10W-1:0]  rec_m10,
  input logic [A01W-1:0]  rec_m01,
  input logic             obj_drop,
  input logic [NUNIT-1:0] unit_busy
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid); // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> $stable(rec_m00) && $stable(rec_m10) && $stable(rec_m01)); // R6
  AST_RECORD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_m00 != '0); // R3
  AST_M10_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> int'(rec_m10) <= (NCOL - 1) * int'(rec_m00)); // R4
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    obj_drop |-> $past(col_vld) && ($past(unit_busy) == {NUNIT{1'b1}})); // R7
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    obj_drop |=> !obj_drop); // R7
endmodule

bind msp_object_splitter msp_splitter_checker #(
  .NCOL(NCOL), .NUNIT(NUNIT), .A00W(A00W), .A10W(A10W), .A01W(A01W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .col_vld(col_vld), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rec_m00(rec_m00), .rec_m10(rec_m10),
  .rec_m01(rec_m01), .obj_drop(obj_drop), .unit_busy(unit_busy)
);

// File: tb/sim_msp_object_splitter.sv
`timescale 1ns/1ps
module sim_msp_object_splitter;
  localparam int NCOL  = 16;
  localparam int NROW  = 16;
  localparam int NUNIT = 4;
  localparam int C1MAX = NROW * (NROW - 1) / 2;
  localparam int QN    = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        col_vld = 1'b0;
  logic [4:0]  col_m00 = '0;
  logic [6:0]  col_m01 = '0;
  logic        rec_ready = 1'b1;
  logic        rec_valid, obj_drop;
  logic [8:0]  rec_m00;
  logic [12:0] rec_m10;
  logic [16:0] rec_m20;
  logic [10:0] rec_m01;
  logic [14:0] rec_m11;

  always #2.5 clk = ~clk;

  msp_object_splitter #(.NCOL(NCOL), .NROW(NROW), .NUNIT(NUNIT), .SECOND_ORDER(1)) u0 (
    .clk(clk), .rst_n(rst_n), .col_vld(col_vld), .col_m00(col_m00), .col_m01(col_m01),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_m00(rec_m00), .rec_m10(rec_m10),
    .rec_m20(rec_m20), .rec_m01(rec_m01), .rec_m11(rec_m11), .obj_drop(obj_drop)
  );

  int tests = 0, fails = 0;
  int e00 [QN], e10 [QN], e20 [QN], e01 [QN], e11 [QN];
  int wr = 0, rd = 0;
  int drops_seen = 0, drops_exp = 0;
  bit mon_en = 1'b0, finished = 1'b0;

  function automatic int cnt_of(int f, int x);
    return ((x * 5 + f * 3) % NROW) + 1;
  endfunction
  function automatic int sum_of(int f, int x);
    return (x * 7 + f * 11) % (C1MAX + 1);
  endfunction

  // monitor, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      if (obj_drop) drops_seen++;
      if (rec_valid && rec_ready) begin
        tests++;
        if (rd == wr) begin
          fails++;
          $display("FAIL R2 R7 unexpected record m00=%0d expected none", rec_m00);
        end else begin
          if (int'(rec_m00) != e00[rd % QN] || int'(rec_m01) != e01[rd % QN] ||
              int'(rec_m10) != e10[rd % QN] || int'(rec_m20) != e20[rd % QN] ||
              int'(rec_m11) != e11[rd % QN]) begin
            fails++;
            $display("FAIL R3 R4 R5 R10 record %0d got %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
                     rd, rec_m00, rec_m10, rec_m20, rec_m01, rec_m11,
                     e00[rd % QN], e10[rd % QN], e20[rd % QN], e01[rd % QN], e11[rd % QN]);
          end
          rd++;
        end
      end
    end
  end

  function automatic void check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // model a frame, push the expected records, then stream it (R2 R9 R10)
  task automatic run_frame(input int f, input int mask, input bit hold);
    int n = 0;
    int a00 = 0, a10 = 0, a20 = 0, a01 = 0, a11 = 0;
    bit in_run = 1'b0;
    for (int x = 0; x < NCOL; x++) begin
      bit occ = mask[x];
      if (occ) begin
        in_run = 1'b1;
        a00 += cnt_of(f, x);
        a10 += x * cnt_of(f, x);
        a20 += x * x * cnt_of(f, x);
        a01 += sum_of(f, x);
        a11 += x * sum_of(f, x);
      end
      if (in_run && (!occ || x == NCOL - 1)) begin
        if (!hold || n < NUNIT) begin
          e00[wr % QN] = a00; e10[wr % QN] = a10; e20[wr % QN] = a20;
          e01[wr % QN] = a01; e11[wr % QN] = a11;
          wr++;
        end else begin
          drops_exp++;
        end
        n++;
        in_run = 1'b0;
        a00 = 0; a10 = 0; a20 = 0; a01 = 0; a11 = 0;
      end
    end
    for (int x = 0; x < NCOL; x++) begin
      if ((f % 2 == 1) && ((x + f) % 5 == 0)) begin
        @(negedge clk);
        col_vld = 1'b0;   // R10: idle beat carrying junk
        col_m00 = 5'd9;
        col_m01 = 7'd33;
      end
      @(negedge clk);
      col_vld = 1'b1;
      col_m00 = mask[x] ? 5'(cnt_of(f, x)) : 5'd0;
      col_m01 = mask[x] ? 7'(sum_of(f, x)) : 7'((x + f) % (C1MAX + 1)); // R2: ignored
    end
    @(negedge clk);
    col_vld = 1'b0;
    col_m00 = '0;
    col_m01 = '0;
  endtask

  task automatic wait_drained(input string req);
    repeat (12) @(negedge clk);
    #2;
    check(rd == wr, req, rd, wr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int specials [6] = '{32'h8000, 32'h0001, 32'hFFFF, 32'hFFFF, 32'h5555, 32'h0000};
    repeat (3) @(negedge clk);
    #1;
    check(rec_valid == 1'b0, "R1 rec_valid in reset", rec_valid, 0);
    check(obj_drop == 1'b0, "R1 obj_drop in reset", obj_drop, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(rec_valid == 1'b0, "R1 rec_valid after reset", rec_valid, 0);
    check(obj_drop == 1'b0, "R1 obj_drop after reset", obj_drop, 0);
    mon_en = 1'b1;

    // sweep with a consumer that is always ready; frames back to back
    // (the first four frames exercise the frame wrap of R9)
    rec_ready = 1'b1;
    for (int f = 0; f < 6; f++) run_frame(f, specials[f], 1'b0);
    for (int f = 6; f < 320; f++) run_frame(f, (f * 40503 + 12345) & 16'hFFFF, 1'b0);
    wait_drained("R2 R5 R9 all records of sweep");
    check(drops_seen == 0, "R7 no drop while ready", drops_seen, 0);

    // pool exhaustion with the consumer held off
    for (int k = 0; k < 24; k++) begin
      int m;
      int hold_rd;
      logic [8:0]  s00;
      logic [12:0] s10;
      logic [10:0] s01;
      case (k % 6)
        0: m = 16'h5555;
        1: m = 16'hAAAA;
        2: m = 16'h9249;
        3: m = 16'h3333;
        4: m = 16'h0F0F;
        default: m = ((k * 40503 + 777) & 16'hFFFF) & 16'h6DB6;
      endcase
      rec_ready = 1'b0;
      hold_rd = rd;
      run_frame(1000 + k, m, 1'b1);
      repeat (2) @(negedge clk);
      #1;
      s00 = rec_m00; s10 = rec_m10; s01 = rec_m01;
      if (wr > hold_rd) begin
        check(rec_valid == 1'b1, "R6 valid while held", rec_valid, 1);
        repeat (3) @(negedge clk);
        #1;
        check(rec_valid == 1'b1 && rec_m00 == s00 && rec_m10 == s10 && rec_m01 == s01,
              "R6 record stable while held", int'(rec_m00), int'(s00));
      end
      @(negedge clk);
      rec_ready = 1'b1;
      wait_drained("R8 drain after hold");
      check(drops_seen == drops_exp, "R7 drop pulse count", drops_seen, drops_exp);
    end

    // units are reused after the held frames
    rec_ready = 1'b1;
    for (int f = 2000; f < 2040; f++) run_frame(f, (f * 2654435 + 99) & 16'hFFFF, 1'b0);
    wait_drained("R8 reuse of units");
    check(drops_seen == drops_exp, "R7 no new drops", drops_seen, drops_exp);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule